// File: doc/BRIEF.md
# Cascaded 12-Bit Successive-Approximation Sequencer

This block drives the digital side of a 12-bit successive-approximation converter. It does so by chaining two bit-sequencing stages. The upper stage decides the four most significant bits. Once the upper stage is done, the lower stage takes over and decides the remaining eight bits. Each clock edge resolves one trial bit from the comparator input and sets the next trial bit. The parallel word therefore doubles as the DAC code and as the final result. The decided bits also leave the block one per clock on a single serial line, most significant first, with no gap where the work passes from one stage to the other.

The two stages rest differently by design. The lower stage sits cleared while it waits for its start, and every new upper start wipes it. In free-running mode the upper stage has no resting state at all: whenever neither stage is busy, the next clock starts a new conversion. A glitch or power-up state therefore cannot park the converter. In strobed mode a rising edge on the strobe input starts a conversion, also in the middle of one, and the result and end flag are held until the next strobe edge.

Top module: `sar12_cascade`

## Requirements
- R1: While `rst_n` is low, `dac_word`, `eoc` and `sout` are all 0.
- R2: In strobed mode (`free_run`=0), a clock edge that sees `strobe`=1 after a clock that saw `strobe`=0 starts a conversion. After that edge `dac_word` is 0x800 (trial bit 11 set, all others 0) and `eoc` is 0.
- R3: Each trial bit is resolved on the edge after it was set. It stays 1 if `cmp`=1 and is cleared if `cmp`=0, and the next lower bit becomes the new trial on the same edge. With `cmp` = (`dac_word` <= input code), the final word equals the input code.
- R4: While the upper stage is working (the first three clocks after a start), `dac_word[7:0]` is 0.
- R5: The edge that resolves bit 8 also sets trial bit 7, so `dac_word[7:0]` is 0x80 four clocks after the start edge. No idle clock lies between the stages.
- R6: `sout` carries each bit's decision during the clock after the edge that resolved it. The bits run MSB first over 12 consecutive clocks that end in the clock where `eoc` rises. `sout` is 0 in the clock after a start and whenever no bit was just resolved.
- R7: `eoc` rises on the edge that resolves bit 0. In strobed mode `eoc` then stays 1, `dac_word` stays unchanged and `sout` stays 0 until the next start.
- R8: A strobe held high starts only one conversion. A new strobe rising edge during a conversion restarts it from 0x800.
- R9: In free-running mode a new conversion starts on every edge where neither stage is busy. Successive `eoc` rises are 13 clocks apart, and `eoc` is high for one clock only.
- R10: In free-running mode `strobe` has no effect: the 13-clock period and the results are unchanged while it toggles.
- R11: In free-running mode the first clock edge after reset release starts a conversion (`dac_word` becomes 0x800). The sequencer has no resting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| free_run | input | 1 | 1 = restart automatically, 0 = start on strobe edges |
| strobe | input | 1 | External start request, edge-detected in strobed mode |
| cmp | input | 1 | Comparator decision: 1 keeps the current trial bit |
| dac_word | output | 12 | DAC code during conversion, result when `eoc` is high |
| eoc | output | 1 | End of the 12-bit conversion |
| sout | output | 1 | Serial result stream, MSB first |

## Verification
A stage pointer stuck on the wrong bit or a lower stage that was not cleared shows in `dac_word` within one to four clocks of a start. This is why the trial pattern and the zero lower byte are checked on each strobed conversion. A broken handoff, or a serial register fed on the wrong cycle, shifts or drops a bit in the 12-bit serial window and corrupts the word that is compared when `eoc` rises, at most 13 clocks after the start. Faults in the restart logic show as a wrong spacing between `eoc` pulses in free-running mode, as an `eoc` that lasts more than one clock, or as a converter that never leaves reset. A watchdog on `eoc` catches the last case.

// File: rtl/sar12_cascade.sv
module sar12_cascade #(
  parameter int HI_W = 4,
  parameter int LO_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 free_run,
  input  logic                 strobe,
  input  logic                 cmp,
  output logic [HI_W+LO_W-1:0] dac_word,
  output logic                 eoc,
  output logic                 sout
);
  localparam logic [HI_W-1:0] HI_MSB = {1'b1, {(HI_W-1){1'b0}}};
  localparam logic [LO_W-1:0] LO_MSB = {1'b1, {(LO_W-1){1'b0}}};

  logic [HI_W-1:0] hi_q, hi_ptr;
  logic [LO_W-1:0] lo_q, lo_ptr;
  logic            eoc_q, so_hi, so_lo, strobe_d;

  wire hi_busy = |hi_ptr;
  wire lo_busy = |lo_ptr;
  wire hi_last = hi_ptr[0];
  wire go_hi   = free_run ? ~(hi_busy | lo_busy) : (strobe & ~strobe_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_d <= 1'b0;
    else        strobe_d <= strobe;
  end

  // upper stage: no resting state in free-run, retriggered by a start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; hi_ptr <= '0; so_hi <= 1'b0;
    end else if (go_hi) begin
      hi_q <= HI_MSB; hi_ptr <= HI_MSB; so_hi <= 1'b0;
    end else if (hi_busy) begin
      hi_q   <= (hi_q & ~(hi_ptr & {HI_W{~cmp}})) | (hi_ptr >> 1);
      hi_ptr <= hi_ptr >> 1;
      so_hi  <= cmp;
    end else begin
      so_hi <= 1'b0;
    end
  end

  // lower stage: cleared by every upper start, started by the upper handoff
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0; lo_ptr <= '0; so_lo <= 1'b0;
    end else if (go_hi) begin
      lo_q <= '0; lo_ptr <= '0; so_lo <= 1'b0;
    end else if (hi_last) begin
      lo_q <= LO_MSB; lo_ptr <= LO_MSB; so_lo <= 1'b0;
    end else if (lo_busy) begin
      lo_q   <= (lo_q & ~(lo_ptr & {LO_W{~cmp}})) | (lo_ptr >> 1);
      lo_ptr <= lo_ptr >> 1;
      so_lo  <= cmp;
    end else begin
      so_lo <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         eoc_q <= 1'b0;
    else if (go_hi)     eoc_q <= 1'b0;
    else if (lo_ptr[0]) eoc_q <= 1'b1;
  end

  assign dac_word = {hi_q, lo_q};
  assign eoc      = eoc_q;
  assign sout     = so_hi | so_lo;
endmodule

// File: rtl/sar12_cascade_chk.sv
module sar12_cascade_chk #(
  parameter int HI_W = 4,
  parameter int LO_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 free_run,
  input logic                 strobe,
  input logic [HI_W+LO_W-1:0] dac_word,
  input logic                 eoc,
  input logic                 sout
);
  localparam int W = HI_W + LO_W;
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  logic s_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_prev <= 1'b0;
    else        s_prev <= strobe;
  end

  p_strobe_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && strobe && !s_prev) |=> (dac_word == TOP && !eoc));

  p_hold_result_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!free_run && eoc && !(strobe && !s_prev)) |=> (eoc && $stable(dac_word)));

  p_quiet_serial_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && $past(eoc)) |-> !sout);

  p_free_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (free_run && eoc) |=> (!eoc && dac_word == TOP));
endmodule

bind sar12_cascade sar12_cascade_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .free_run(free_run), .strobe(strobe),
  .dac_word(dac_word), .eoc(eoc), .sout(sout)
);

// File: tb/tb_sar12_cascade.sv
`timescale 1ns/1ps
module tb_sar12_cascade;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        free_run = 1'b0;
  logic        strobe = 1'b0;
  logic [11:0] vin = 12'h000;
  logic [11:0] dac_word;
  logic        eoc, sout, cmp;

  int checks = 0, errors = 0;
  int cyc = 0, n_done = 0;
  logic [11:0] expq[$];
  logic [11:0] sh = '0;
  logic        eoc_prev = 1'b0, last_fr = 1'b0, fr_rise_prev = 1'b0;
  int          last_cyc = 0;

  always #2 clk = ~clk;

  assign cmp = (dac_word <= vin);

  sar12_cascade dut (
    .clk(clk), .rst_n(rst_n), .free_run(free_run), .strobe(strobe),
    .cmp(cmp), .dac_word(dac_word), .eoc(eoc), .sout(sout)
  );

  task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // monitor: scoreboard pop on each eoc rise
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      sh = '0; eoc_prev = 1'b0; last_fr = 1'b0; fr_rise_prev = 1'b0;
    end else begin
      sh = {sh[10:0], sout};
      if (fr_rise_prev && free_run)
        chk(!eoc, "R9 eoc one clock", {11'b0, eoc}, 12'h000);
      fr_rise_prev = 1'b0;
      if (eoc && !eoc_prev) begin
        n_done++;
        if (expq.size() == 0) chk(1'b0, "R3 unexpected eoc", dac_word, 12'h000);
        else begin
          logic [11:0] e;
          e = expq.pop_front();
          chk(dac_word == e, "R3 result word", dac_word, e);
          chk(sh == e, "R6 serial word", sh, e);
        end
        if (free_run && last_fr)
          chk(cyc - last_cyc == 13, "R9 period", 12'(cyc - last_cyc), 12'd13);
        last_fr = free_run;
        last_cyc = cyc;
        fr_rise_prev = free_run;
      end
      eoc_prev = eoc;
    end
  end

  task automatic convert(input logic [11:0] v);
    vin = v;
    expq.push_back(v);
    step(); strobe = 1'b1;
    step(); strobe = 1'b0;
    chk(dac_word == 12'h800, "R2 start word", dac_word, 12'h800);
    chk(!eoc, "R2 eoc low", {11'b0, eoc}, 12'h000);
    chk(!sout, "R6 start cycle quiet", {11'b0, sout}, 12'h000);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(dac_word[7:0] == 8'h00, "R4 lower cleared", {4'h0, dac_word[7:0]}, 12'h000);
    end
    step();
    chk(dac_word[7:0] == 8'h80, "R5 handoff", {4'h0, dac_word[7:0]}, 12'h080);
    while (!eoc) step();
    repeat (4) step();
    chk(eoc && !sout && dac_word == v, "R7 hold", dac_word, v);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) step();
    chk(dac_word == 12'h000 && !eoc && !sout, "R1 reset", dac_word, 12'h000);
    rst_n = 1'b1;
    step();
    chk(dac_word == 12'h000 && !eoc, "R1 idle strobed", dac_word, 12'h000);

    convert(12'h000);
    convert(12'hFFF);
    convert(12'h800);
    convert(12'h7FF);
    convert(12'hA5C);
    convert(12'h001);
    convert(12'h0F0);
    convert(12'hF0F);

    // R8 retrigger mid conversion
    vin = 12'h123;
    step(); strobe = 1'b1;
    step(); strobe = 1'b0;
    repeat (4) step();
    vin = 12'hABC;
    expq.push_back(12'hABC);
    strobe = 1'b1;
    step(); strobe = 1'b0;
    chk(dac_word == 12'h800, "R8 retrigger", dac_word, 12'h800);
    while (!eoc) step();
    step();

    // R8 held strobe starts one conversion
    begin
      int n0;
      n0 = n_done;
      vin = 12'h5A5;
      expq.push_back(12'h5A5);
      step(); strobe = 1'b1;
      repeat (40) step();
      chk(n_done == n0 + 1, "R8 held strobe", 12'(n_done - n0), 12'd1);
      chk(eoc && dac_word == 12'h5A5, "R8 held result", dac_word, 12'h5A5);
      strobe = 1'b0;
      step();
    end

    // R9 R10 free run with toggling strobe
    begin
      int n0;
      n0 = n_done;
      vin = 12'h3C7;
      repeat (4) expq.push_back(12'h3C7);
      free_run = 1'b1;
      while (n_done < n0 + 4) begin step(); strobe = ~strobe; end
      free_run = 1'b0; strobe = 1'b0;
      step();
      chk(eoc && dac_word == 12'h3C7, "R10 free-run result", dac_word, 12'h3C7);
    end

    // R11 no resting state after reset in free run
    begin
      int n0;
      rst_n = 1'b0;
      free_run = 1'b1;
      vin = 12'h6D2;
      step(); step();
      chk(dac_word == 12'h000 && !eoc && !sout, "R1 second reset", dac_word, 12'h000);
      n0 = n_done;
      repeat (2) expq.push_back(12'h6D2);
      rst_n = 1'b1;
      step();
      chk(dac_word == 12'h800, "R11 auto start", dac_word, 12'h800);
      while (n_done < n0 + 2) step();
      free_run = 1'b0;
      step();
      chk(expq.size() == 0, "R9 queue drained", 12'(expq.size()), 12'd0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule